// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control state machine of a processor that spends several clock cycles on each instruction. It reads the 6-bit opcode held in the instruction register and the registered operand-equality flag. Each cycle it drives the datapath's control points: the memory strobes, the register load enables, the ALU operation and operand source, the immediate extension mode, the register-file destination and write strobe, the write-back source and the next-PC choice. Every instruction starts with a fetch state and a shared decode state. It then takes a chain of states for its class and comes back to fetch. A branch takes 3 cycles, an ALU register, OR-immediate or store instruction takes 4, and a load takes 5.

The state codes are fixed. They are fetch `0000`, decode `0001`, branch resolve `0011`, register-ALU execute `0100` and write `0101`, OR-immediate execute `0110` and write `0111`, load address `1000`, load memory `1001` and load write `1010`, and store address `1011` and store memory `1100`. The transitions are fetch→decode. Decode goes to one of five class entries, or back to fetch for an opcode it does not know. The chain steps are execute→write and address→memory→write. The final states (`0101`, `0111`, `1010`, `1100`, `0011`) return to fetch. The datapath performs each register transfer on the clock edge that leaves the state asserting it. The current state is visible on a port. A second port reports how many cycles the most recently completed instruction took.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low the state is `0000` and `last_cycles` is 0. Reset takes effect at once, even in the middle of an instruction.
- R2: In state `0000` only `mem_rd` and `ir_en` are high, and the next state is always `0001`.
- R3: In state `0001` only `a_en`, `b_en` and `e_en` are high. The next state is `0100` for opcode 000000, `0110` for 001101, `1000` for 100011, `1011` for 101011 and `0011` for 000100.
- R4: The register-ALU path is `0100` then `0101` then `0000`. State `0100` drives `s_en` with `alu_op`=10 (use the function field) and `alu_src_imm`=0. State `0101` drives `reg_wr`, `dst_rd` and `pc_en`.
- R5: The OR-immediate path is `0110` then `0111` then `0000`. State `0110` drives `s_en`, `alu_op`=01 (OR), `alu_src_imm`=1 and `ext_sign`=0. State `0111` drives `reg_wr` and `pc_en`, with `dst_rd`=0.
- R6: The load path is `1000` then `1001` then `1010` then `0000`. State `1000` drives `s_en`, `alu_op`=00 (add), `alu_src_imm`=1 and `ext_sign`=1. State `1001` drives `mem_rd` and `m_en`. State `1010` drives `reg_wr`, `wb_from_mem` and `pc_en`, with `dst_rd`=0.
- R7: The store path is `1011` then `1100` then `0000`. State `1011` drives the same controls as `1000`. State `1100` drives `mem_wr` and `pc_en`.
- R8: State `0011` drives `pc_en`, and `pc_br_sel` follows `eq_flag`. It then returns to `0000`.
- R9: For any other opcode, state `0001` returns to `0000`. No write strobe or PC enable is raised along the way, and `last_cycles` keeps its value.
- R10: Any control point not named for a state is 0 in that state. `alu_op` is 00 wherever no operation is named. `mem_rd` and `mem_wr` are never high together.
- R11: `last_cycles` takes the instruction's cycle count (3 branch, 4 register-ALU/OR-immediate/store, 5 load) on the edge that leaves its final state, and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| eq_flag | input | 1 | Registered operand-equality flag |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_en | output | 1 | Instruction register load |
| a_en | output | 1 | Operand A register load |
| b_en | output | 1 | Operand B register load |
| e_en | output | 1 | Equality flag register load |
| s_en | output | 1 | ALU result register load |
| m_en | output | 1 | Memory data register load |
| pc_en | output | 1 | PC load |
| pc_br_sel | output | 1 | 1 selects the branch target, 0 selects PC+4 |
| alu_op | output | 2 | 00 add, 01 OR, 10 function field |
| alu_src_imm | output | 1 | 1 selects the extended immediate as ALU operand B |
| ext_sign | output | 1 | 1 sign-extends the immediate, 0 zero-extends it |
| dst_rd | output | 1 | 1 writes the rd field, 0 writes the rt field |
| reg_wr | output | 1 | Register file write strobe |
| wb_from_mem | output | 1 | 1 writes back memory data, 0 writes back the ALU result |
| fsm_state | output | 4 | Current state code |
| last_cycles | output | 4 | Cycle count of the last completed instruction |

## Verification
A wrong state is visible on `fsm_state` in the same cycle. It shows on the control outputs in that cycle too, because they depend only on the state. The bench compares the state and the whole control word on every cycle of every instruction. It does this for all 64 opcodes with both flag values, so a bad transition or a misdecoded control point is reported in the cycle where it first appears. A wrong cycle count or a spurious update shows on `last_cycles` one cycle after the instruction ends, when the machine is back in fetch.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int OPC_W  = 6;
    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH   = 4'b0000,
        ST_DECODE  = 4'b0001,
        ST_BR      = 4'b0011,
        ST_RT_EXE  = 4'b0100,
        ST_RT_WB   = 4'b0101,
        ST_ORI_EXE = 4'b0110,
        ST_ORI_WB  = 4'b0111,
        ST_LW_ADR  = 4'b1000,
        ST_LW_MEM  = 4'b1001,
        ST_LW_WB   = 4'b1010,
        ST_SW_ADR  = 4'b1011,
        ST_SW_MEM  = 4'b1100
    } ctrl_state_e;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_OR   = 2'b01,
        ALU_FUNC = 2'b10
    } alu_op_e;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_LW    = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_SW    = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;

    typedef struct packed {
        logic    mem_rd;
        logic    mem_wr;
        logic    ir_en;
        logic    a_en;
        logic    b_en;
        logic    e_en;
        logic    s_en;
        logic    m_en;
        logic    pc_en;
        logic    pc_br_sel;
        alu_op_e alu_op;
        logic    alu_src_imm;
        logic    ext_sign;
        logic    dst_rd;
        logic    reg_wr;
        logic    wb_from_mem;
    } ctrl_word_t;

endpackage

// File: rtl/mc_next_state.sv
module mc_next_state
    import mc_ctrl_pkg::*;
(
    input  ctrl_state_e      cur,
    input  logic [OPC_W-1:0] opcode,
    output ctrl_state_e      nxt
);
    always_comb begin
        nxt = ST_FETCH;
        unique case (cur)
            ST_FETCH:   nxt = ST_DECODE;
            ST_DECODE: begin
                if      (opcode == OPC_RTYPE) nxt = ST_RT_EXE;
                else if (opcode == OPC_ORI)   nxt = ST_ORI_EXE;
                else if (opcode == OPC_LW)    nxt = ST_LW_ADR;
                else if (opcode == OPC_SW)    nxt = ST_SW_ADR;
                else if (opcode == OPC_BEQ)   nxt = ST_BR;
                else                          nxt = ST_FETCH;
            end
            ST_RT_EXE:  nxt = ST_RT_WB;
            ST_ORI_EXE: nxt = ST_ORI_WB;
            ST_LW_ADR:  nxt = ST_LW_MEM;
            ST_LW_MEM:  nxt = ST_LW_WB;
            ST_SW_ADR:  nxt = ST_SW_MEM;
            ST_RT_WB, ST_ORI_WB, ST_LW_WB, ST_SW_MEM, ST_BR:
                        nxt = ST_FETCH;
            default:    nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
    import mc_ctrl_pkg::*;
(
    input  ctrl_state_e cur,
    input  logic        eq_flag,
    output ctrl_word_t  cw,
    output logic        retire
);
    always_comb begin
        cw     = '0;
        retire = 1'b0;
        unique case (cur)
            ST_FETCH: begin
                cw.mem_rd = 1'b1;
                cw.ir_en  = 1'b1;
            end
            ST_DECODE: begin
                cw.a_en = 1'b1;
                cw.b_en = 1'b1;
                cw.e_en = 1'b1;
            end
            ST_RT_EXE: begin
                cw.alu_op = ALU_FUNC;
                cw.s_en   = 1'b1;
            end
            ST_RT_WB: begin
                cw.reg_wr = 1'b1;
                cw.dst_rd = 1'b1;
                cw.pc_en  = 1'b1;
                retire    = 1'b1;
            end
            ST_ORI_EXE: begin
                cw.alu_op      = ALU_OR;
                cw.alu_src_imm = 1'b1;
                cw.s_en        = 1'b1;
            end
            ST_ORI_WB: begin
                cw.reg_wr = 1'b1;
                cw.pc_en  = 1'b1;
                retire    = 1'b1;
            end
            ST_LW_ADR, ST_SW_ADR: begin
                cw.alu_op      = ALU_ADD;
                cw.alu_src_imm = 1'b1;
                cw.ext_sign    = 1'b1;
                cw.s_en        = 1'b1;
            end
            ST_LW_MEM: begin
                cw.mem_rd = 1'b1;
                cw.m_en   = 1'b1;
            end
            ST_LW_WB: begin
                cw.reg_wr      = 1'b1;
                cw.wb_from_mem = 1'b1;
                cw.pc_en       = 1'b1;
                retire         = 1'b1;
            end
            ST_SW_MEM: begin
                cw.mem_wr = 1'b1;
                cw.pc_en  = 1'b1;
                retire    = 1'b1;
            end
            ST_BR: begin
                cw.pc_en     = 1'b1;
                cw.pc_br_sel = eq_flag;
                retire       = 1'b1;
            end
            default: begin
                cw     = '0;
                retire = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mc_cycle_count.sv
module mc_cycle_count #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             to_fetch,
    input  logic             retire,
    output logic [CNT_W-1:0] last_cycles
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] step_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q      <= '0;
            last_cycles <= '0;
        end else begin
            step_q <= to_fetch ? '0 : step_q + ONE;
            if (retire) begin
                last_cycles <= step_q + ONE;
            end
        end
    end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        opcode,
    input  logic              eq_flag,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              ir_en,
    output logic              a_en,
    output logic              b_en,
    output logic              e_en,
    output logic              s_en,
    output logic              m_en,
    output logic              pc_en,
    output logic              pc_br_sel,
    output logic [1:0]        alu_op,
    output logic              alu_src_imm,
    output logic              ext_sign,
    output logic              dst_rd,
    output logic              reg_wr,
    output logic              wb_from_mem,
    output logic [3:0]        fsm_state,
    output logic [CNT_W-1:0]  last_cycles
);
    ctrl_state_e state_q;
    ctrl_state_e state_d;
    ctrl_word_t  cw;
    logic        retire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    mc_next_state u_next (
        .cur    (state_q),
        .opcode (opcode),
        .nxt    (state_d)
    );

    mc_ctrl_decode u_dec (
        .cur     (state_q),
        .eq_flag (eq_flag),
        .cw      (cw),
        .retire  (retire)
    );

    mc_cycle_count #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .to_fetch    (state_d == ST_FETCH),
        .retire      (retire),
        .last_cycles (last_cycles)
    );

    assign mem_rd      = cw.mem_rd;
    assign mem_wr      = cw.mem_wr;
    assign ir_en       = cw.ir_en;
    assign a_en        = cw.a_en;
    assign b_en        = cw.b_en;
    assign e_en        = cw.e_en;
    assign s_en        = cw.s_en;
    assign m_en        = cw.m_en;
    assign pc_en       = cw.pc_en;
    assign pc_br_sel   = cw.pc_br_sel;
    assign alu_op      = cw.alu_op;
    assign alu_src_imm = cw.alu_src_imm;
    assign ext_sign    = cw.ext_sign;
    assign dst_rd      = cw.dst_rd;
    assign reg_wr      = cw.reg_wr;
    assign wb_from_mem = cw.wb_from_mem;
    assign fsm_state   = state_q;
endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [5:0]       opcode,
    input logic             eq_flag,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic             a_en,
    input logic             b_en,
    input logic             e_en,
    input logic             m_en,
    input logic             pc_en,
    input logic             pc_br_sel,
    input logic             reg_wr,
    input logic [3:0]       fsm_state,
    input logic [CNT_W-1:0] last_cycles
);
    logic known_op;
    assign known_op = (opcode == 6'b000000) || (opcode == 6'b001101) ||
                      (opcode == 6'b100011) || (opcode == 6'b101011) ||
                      (opcode == 6'b000100);

    p_fetch_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == 4'b0000) |=> (fsm_state == 4'b0001));

    p_decode_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == 4'b0001) |-> (a_en && b_en && e_en));

    p_rt_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == 4'b0101) |=> (fsm_state == 4'b0000));

    p_lw_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == 4'b1001) |-> (mem_rd && m_en && !reg_wr));

    p_br_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == 4'b0011) |-> (pc_en && (pc_br_sel == eq_flag)));

    p_bad_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_state == 4'b0001) && !known_op) |=> (fsm_state == 4'b0000));

    p_mem_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_cycles_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(last_cycles) |->
            ((last_cycles == CNT_W'(3)) || (last_cycles == CNT_W'(4)) ||
             (last_cycles == CNT_W'(5))));
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .opcode      (opcode),
    .eq_flag     (eq_flag),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .a_en        (a_en),
    .b_en        (b_en),
    .e_en        (e_en),
    .m_en        (m_en),
    .pc_en       (pc_en),
    .pc_br_sel   (pc_br_sel),
    .reg_wr      (reg_wr),
    .fsm_state   (fsm_state),
    .last_cycles (last_cycles)
);

// File: tb/tb_mc_ctrl_fsm.sv
module tb_mc_ctrl_fsm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = '0;
    logic       eq_flag = 1'b0;
    logic       mem_rd, mem_wr, ir_en, a_en, b_en, e_en, s_en, m_en;
    logic       pc_en, pc_br_sel, alu_src_imm, ext_sign, dst_rd, reg_wr, wb_from_mem;
    logic [1:0] alu_op;
    logic [3:0] fsm_state;
    logic [3:0] last_cycles;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mc_ctrl_fsm dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .eq_flag(eq_flag),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_en(ir_en), .a_en(a_en),
        .b_en(b_en), .e_en(e_en), .s_en(s_en), .m_en(m_en), .pc_en(pc_en),
        .pc_br_sel(pc_br_sel), .alu_op(alu_op), .alu_src_imm(alu_src_imm),
        .ext_sign(ext_sign), .dst_rd(dst_rd), .reg_wr(reg_wr),
        .wb_from_mem(wb_from_mem), .fsm_state(fsm_state),
        .last_cycles(last_cycles)
    );

    // order: mem_rd mem_wr ir_en a_en b_en e_en s_en m_en pc_en pc_br_sel
    //        alu_op[1:0] alu_src_imm ext_sign dst_rd reg_wr wb_from_mem
    function automatic logic [16:0] exp_word(input logic [3:0] st, input logic eq);
        case (st)
            4'b0000: return 17'b1_0_1_0_0_0_0_0_0_0_00_0_0_0_0_0;
            4'b0001: return 17'b0_0_0_1_1_1_0_0_0_0_00_0_0_0_0_0;
            4'b0100: return 17'b0_0_0_0_0_0_1_0_0_0_10_0_0_0_0_0;
            4'b0101: return 17'b0_0_0_0_0_0_0_0_1_0_00_0_0_1_1_0;
            4'b0110: return 17'b0_0_0_0_0_0_1_0_0_0_01_1_0_0_0_0;
            4'b0111: return 17'b0_0_0_0_0_0_0_0_1_0_00_0_0_0_1_0;
            4'b1000: return 17'b0_0_0_0_0_0_1_0_0_0_00_1_1_0_0_0;
            4'b1001: return 17'b1_0_0_0_0_0_0_1_0_0_00_0_0_0_0_0;
            4'b1010: return 17'b0_0_0_0_0_0_0_0_1_0_00_0_0_0_1_1;
            4'b1011: return 17'b0_0_0_0_0_0_1_0_0_0_00_1_1_0_0_0;
            4'b1100: return 17'b0_1_0_0_0_0_0_0_1_0_00_0_0_0_0_0;
            4'b0011: return {9'b0_0_0_0_0_0_0_0_1, eq, 7'b00_0_0_0_0_0};
            default: return 17'h1ffff;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] st);
        case (st)
            4'b0000: return "R2";
            4'b0001: return "R3";
            4'b0100, 4'b0101: return "R4";
            4'b0110, 4'b0111: return "R5";
            4'b1000, 4'b1001, 4'b1010: return "R6";
            4'b1011, 4'b1100: return "R7";
            4'b0011: return "R8";
            default: return "R10";
        endcase
    endfunction

    // class chain after decode, from the opcode table of R3
    function automatic int path_of(input logic [5:0] op, output logic [3:0] seq [6]);
        seq[0] = 4'b0000; seq[1] = 4'b0001;
        for (int k = 2; k < 6; k++) seq[k] = 4'b0000;
        case (op)
            6'b000000: begin seq[2] = 4'b0100; seq[3] = 4'b0101; return 4; end
            6'b001101: begin seq[2] = 4'b0110; seq[3] = 4'b0111; return 4; end
            6'b100011: begin seq[2] = 4'b1000; seq[3] = 4'b1001; seq[4] = 4'b1010; return 5; end
            6'b101011: begin seq[2] = 4'b1011; seq[3] = 4'b1100; return 4; end
            6'b000100: begin seq[2] = 4'b0011; return 3; end
            default:   return 2;
        endcase
    endfunction

    function automatic logic [16:0] act_word();
        return {mem_rd, mem_wr, ir_en, a_en, b_en, e_en, s_en, m_en, pc_en,
                pc_br_sel, alu_op, alu_src_imm, ext_sign, dst_rd, reg_wr, wb_from_mem};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    logic [3:0] exp_last = '0;

    task automatic run_one(input logic [5:0] op, input logic eq);
        logic [3:0] seq [6];
        int n;
        n = path_of(op, seq);
        opcode  = op;
        eq_flag = eq;
        for (int k = 0; k < n; k++) begin
            #0;
            check(tag_of(seq[k]), "state", 32'(fsm_state), 32'(seq[k]));
            check((n == 2 && k == 1) ? "R9" : tag_of(seq[k]), "controls",
                  32'(act_word()), 32'(exp_word(seq[k], eq)));
            @(negedge clk);
        end
        check((n == 2) ? "R9" : "R11", "return to fetch", 32'(fsm_state), 32'h0);
        if (n > 2) exp_last = 4'(n);
        check((n == 2) ? "R9" : "R11", "last_cycles", 32'(last_cycles), 32'(exp_last));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset state", 32'(fsm_state), 32'h0);
        check("R1", "reset last_cycles", 32'(last_cycles), 32'h0);
        check("R1", "reset controls", 32'(act_word()), 32'(exp_word(4'b0000, 1'b0)));
        rst_n = 1'b1;
        // near-exhaustive sweep: every opcode, both flag values
        for (int e = 0; e < 2; e++) begin
            for (int o = 0; o < 64; o++) begin
                run_one(6'(o), e[0]);
            end
        end
        // back-to-back classes so that the count follows each instruction
        run_one(6'b000100, 1'b1);
        run_one(6'b100011, 1'b0);
        run_one(6'b111111, 1'b0);
        run_one(6'b101011, 1'b1);
        // R1: reset in the middle of a load
        opcode = 6'b100011;
        repeat (3) @(negedge clk);
        check("R6", "in load memory state", 32'(fsm_state), 32'h9);
        rst_n = 1'b0;
        #1;
        check("R1", "mid-instruction reset state", 32'(fsm_state), 32'h0);
        check("R1", "mid-instruction reset count", 32'(last_cycles), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        exp_last = '0;
        run_one(6'b001101, 1'b0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule